// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Static Memory Model

This block is a clocked, synthesizable stand-in for a 32-bit asynchronous static memory built from two banks. It is meant to sit opposite a memory controller in simulation and give it a target whose behaviour can be checked. Both banks share one word address. Two active-low selects pick the bank: only one may be low at a time. Each of the four byte lanes has its own active-low write strobe and its own active-low output enable.

All pins are sampled on the rising clock edge. A write takes effect at that edge. Read data and the per-lane drive flags are registered, so they appear one clock after the address and strobes were presented. The bidirectional data bus is split into an input bus, an output bus and one drive flag per lane. A lane that is not driven shows zero on the output bus. If both selects are low, the model raises a registered conflict flag and does nothing else. The depth is a parameter, so simulation can use a small memory. Memory contents are not initialised by reset.

The pins carry no stream. They are plain strobes, with no valid/ready handshake and no back-pressure: every sampled edge is one complete access.

Top module: `sram_dualbank_model`

## Requirements
- R1: With sel_a_n=0 and sel_b_n=1 the low bank is accessed. With sel_a_n=1 and sel_b_n=0 the high bank is accessed. The two banks hold separate data at the same address.
- R2: With both selects high, no lane is written. In the next cycle lane_drive is 4'b0000 and rdata is zero.
- R3: With both selects low, no lane is written. In the next cycle conflict is 1 and lane_drive is 4'b0000.
- R4: For a selected bank, wr_n[n]=0 writes din[8n+7:8n] into lane n at the address, whatever oe_n[n] is. Lanes whose wr_n bit is 1 keep their contents.
- R5: A lane whose wr_n bit was 0 at an edge has lane_drive[n]=0 in the following cycle.
- R6: For a selected bank, wr_n[n]=1 with oe_n[n]=0 gives lane_drive[n]=1 in the following cycle, and rdata[8n+7:8n] then holds the byte stored at that address before the edge.
- R7: A lane with lane_drive[n]=0 shows zero on rdata[8n+7:8n]. oe_n[n]=1 together with wr_n[n]=1 leaves that lane undriven.
- R8: conflict is 0 in the cycle after any edge at which the selects were not both low.
- R9: While reset is held and in the cycle after it, lane_drive, rdata and conflict are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| addr | input | ADDR_W | Word address shared by both banks |
| sel_a_n | input | 1 | Active-low select; low alone picks the low bank |
| sel_b_n | input | 1 | Active-low select; low alone picks the high bank |
| wr_n | input | LANES | Active-low write strobe, one per byte lane |
| oe_n | input | LANES | Active-low output enable, one per byte lane |
| din | input | LANES*LANE_W | Write data, lane n on bits 8n+7:8n |
| rdata | output | LANES*LANE_W | Registered read data, zero on undriven lanes |
| lane_drive | output | LANES | Registered per-lane drive flag (1 = lane driven) |
| conflict | output | 1 | Registered flag: both selects were low at the last edge |

## Verification
The hardest case to reach from the pins is one edge that writes some lanes of a word and reads the other lanes of the same word. To show that only the strobed lanes changed and that the read lanes carried the old bytes, the stimulus first fills the word with a known value in both banks. It then issues the mixed cycle with every output enable low, so the write-over-read rule decides each lane. The same priming is used to prove that writes with both selects low, or both high, are lost: the primed words are read back afterwards.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;
  typedef enum logic {
    BANK_LO = 1'b0,
    BANK_HI = 1'b1
  } bank_t;
endpackage

// File: rtl/bank_decode.sv
module bank_decode
  import sram_model_pkg::*;
(
  input  logic  sel_a_n,
  input  logic  sel_b_n,
  output logic  active,
  output bank_t bank,
  output logic  clash
);
  always_comb begin
    active = 1'b0;
    bank   = BANK_LO;
    clash  = 1'b0;
    unique case ({sel_a_n, sel_b_n})
      2'b01: begin active = 1'b1; bank = BANK_LO; end
      2'b10: begin active = 1'b1; bank = BANK_HI; end
      2'b00: clash = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/byte_lane_store.sv
module byte_lane_store
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  bank_t             bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata,
  output logic              drive
);
  localparam int IDX_W = ADDR_W + 1;
  localparam int DEPTH = 2 ** IDX_W;

  logic [LANE_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic              armed;

  assign idx = {logic'(bank), addr};

  // storage: no reset, contents undefined until written
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      drive <= 1'b0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      drive <= rd_en;
      rdata <= rd_en ? mem[idx] : '0;
    end
  end

  AST_LANE_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(wr_en) |-> !drive); // R5
  AST_LANE_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(rd_en) |-> drive); // R6
endmodule

// File: rtl/sram_dualbank_model.sv
module sram_dualbank_model
  import sram_model_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic [LANES-1:0]        wr_n,
  input  logic [LANES-1:0]        oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        lane_drive,
  output logic                    conflict
);
  localparam int DATA_W = LANES * LANE_W;

  logic  active;
  logic  clash;
  bank_t bank;
  logic  armed;

  bank_decode u_decode (
    .sel_a_n (sel_a_n),
    .sel_b_n (sel_b_n),
    .active  (active),
    .bank    (bank),
    .clash   (clash)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    logic lane_wr;
    logic lane_rd;
    // write strobe wins over output enable on the same lane
    assign lane_wr = active && !wr_n[n];
    assign lane_rd = active && wr_n[n] && !oe_n[n];

    byte_lane_store #(
      .ADDR_W (ADDR_W),
      .LANE_W (LANE_W)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (lane_wr),
      .rd_en (lane_rd),
      .bank  (bank),
      .addr  (addr),
      .wdata (din[n*LANE_W +: LANE_W]),
      .rdata (rdata[n*LANE_W +: LANE_W]),
      .drive (lane_drive[n])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      conflict <= 1'b0;
      armed    <= 1'b0;
    end else begin
      conflict <= clash;
      armed    <= 1'b1;
    end
  end

  AST_CONFLICT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> lane_drive == '0); // R3
  AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(sel_a_n && sel_b_n) |-> lane_drive == '0); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lane_drive == '0 |-> rdata == DATA_W'(0)); // R7
  AST_CONFLICT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(sel_a_n || sel_b_n) |-> !conflict); // R8
endmodule

// File: tb/test_sram_dualbank_model.sv
module test_sram_dualbank_model;
  localparam int ADDR_W = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic        sel_a_n = 1'b1, sel_b_n = 1'b1;
  logic [3:0]  wr_n = 4'hF, oe_n = 4'hF;
  logic [31:0] din = '0;
  logic [31:0] rdata;
  logic [3:0]  lane_drive;
  logic        conflict;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sram_dualbank_model #(.ADDR_W(ADDR_W)) i_sram_dualbank_model (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .wr_n(wr_n), .oe_n(oe_n), .din(din), .rdata(rdata),
    .lane_drive(lane_drive), .conflict(conflict)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // present pins, let one edge sample them, settle
  task automatic cycle(logic sa, logic sb, logic [ADDR_W-1:0] a,
                       logic [3:0] w, logic [3:0] o, logic [31:0] d);
    sel_a_n = sa; sel_b_n = sb; addr = a; wr_n = w; oe_n = o; din = d;
    @(posedge clk); #1;
  endtask

  task automatic idle();
    cycle(1'b1, 1'b1, '0, 4'hF, 4'hF, '0);
  endtask

  task automatic wr_word(logic hi, logic [ADDR_W-1:0] a, logic [31:0] d);
    cycle(hi, !hi, a, 4'h0, 4'hF, d);
  endtask

  task automatic rd_check(string req, logic hi, logic [ADDR_W-1:0] a, logic [31:0] exp);
    cycle(hi, !hi, a, 4'hF, 4'h0, '0);
    check(req, rdata, exp);
    check(req, {28'd0, lane_drive}, 32'hF);
  endtask

  task automatic t_reset();
    @(posedge clk); #1;
    check("R9 drive in reset", {28'd0, lane_drive}, 0);
    check("R9 data in reset", rdata, 0);
    check("R9 conflict in reset", {31'd0, conflict}, 0);
    rst_n = 1'b1;
    idle();
    check("R9 drive after reset", {28'd0, lane_drive}, 0);
  endtask

  task automatic t_banks();
    wr_word(1'b0, 6'd5, 32'hA1B2C3D4);
    wr_word(1'b1, 6'd5, 32'h11223344);
    rd_check("R1 low bank", 1'b0, 6'd5, 32'hA1B2C3D4);
    rd_check("R1 high bank", 1'b1, 6'd5, 32'h11223344);
    for (int i = 0; i < 8; i++) wr_word(1'b1, 6'(i + 16), 32'hC0DE0000 + 32'(i * 7));
    for (int i = 0; i < 8; i++) rd_check("R6 multi address", 1'b1, 6'(i + 16), 32'hC0DE0000 + 32'(i * 7));
  endtask

  task automatic t_lane_mix();
    // lane 1 written, lanes 0,2,3 read old data, all output enables low
    cycle(1'b0, 1'b1, 6'd5, 4'b1101, 4'b0000, 32'hEEEE55EE);
    check("R5 written lane undriven", {28'd0, lane_drive}, 32'b1101);
    check("R6 other lanes old data", rdata, 32'hA1B200D4);
    rd_check("R4 lane write merged", 1'b0, 6'd5, 32'hA1B255D4);
  endtask

  task automatic t_standby();
    cycle(1'b1, 1'b1, 6'd5, 4'h0, 4'h0, 32'hDEADBEEF);
    check("R2 standby drive", {28'd0, lane_drive}, 0);
    check("R2 standby data", rdata, 0);
    rd_check("R2 no standby write", 1'b0, 6'd5, 32'hA1B255D4);
  endtask

  task automatic t_conflict();
    cycle(1'b0, 1'b0, 6'd5, 4'b1100, 4'h0, 32'h0BADF00D);
    check("R3 conflict flag", {31'd0, conflict}, 1);
    check("R3 conflict no drive", {28'd0, lane_drive}, 0);
    cycle(1'b0, 1'b0, 6'd5, 4'h0, 4'h0, 32'h0BADF00D);
    check("R3 conflict held", {31'd0, conflict}, 1);
    idle();
    check("R8 conflict cleared", {31'd0, conflict}, 0);
    rd_check("R3 low bank untouched", 1'b0, 6'd5, 32'hA1B255D4);
    check("R8 conflict low on read", {31'd0, conflict}, 0);
    rd_check("R3 high bank untouched", 1'b1, 6'd5, 32'h11223344);
  endtask

  task automatic t_oe_high();
    cycle(1'b1, 1'b0, 6'd5, 4'hF, 4'b0101, '0);
    check("R7 partial drive", {28'd0, lane_drive}, 32'b1010);
    check("R7 undriven lanes zero", rdata, 32'h11003300);
    cycle(1'b1, 1'b0, 6'd5, 4'hF, 4'hF, '0);
    check("R7 no enables", {28'd0, lane_drive}, 0);
    // R4: write with output enables low still writes
    cycle(1'b1, 1'b0, 6'd9, 4'b0111, 4'h0, 32'h9A000000);
    cycle(1'b1, 1'b0, 6'd9, 4'b1000, 4'h0, 32'h00BCDEF0);
    rd_check("R4 write beats enable", 1'b1, 6'd9, 32'h9ABCDEF0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_banks();
    t_lane_mix();
    t_standby();
    t_conflict();
    t_oe_high();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule